// File: doc/BRIEF.md
# Interrupt Acknowledge Snapshot and Vector Generator

This block sits between an interrupt arbitration network and the host bus. The arbitration network reports three things: the current winning source (its channel, type code and priority value) and a flag that says whether that winner is above the service threshold. The host can ask the block to take a snapshot of that result in two ways. It can run an interrupt-acknowledge cycle, or it can issue an update command. The snapshot is frozen in a current-interrupt register and stays there until the next acknowledge or update. Changes in the arbitration inputs between those events have no effect on it.

An acknowledge cycle works as a special read: one cycle after the strobe, the block presents an 8-bit vector with a valid pulse. The vector comes from one of three sources:

- a fixed constant;
- a programmable base register;
- the base register with the captured type code and/or channel inserted.

The channel held in the snapshot sets the interrupt context. Global alias accesses, such as a read or write of a global receive FIFO, are steered to the FIFO of that channel.

Top module: `irq_ack_vector`

## Requirements
- R1: After reset the snapshot register reads 0x00, the vector output reads 0x00, the vector-valid output is low, and the programmable base register holds 0x0F.
- R2: When `ack_stb` or `upd_stb` is high at a clock edge and `arb_valid` is high, `cir_q` shows `{arb_chan, arb_type, arb_prio}` after that edge. The layout is bit 7 = channel (0 = channel A, 1 = channel B), bits 6:4 = type code, bits 3:0 = priority.
- R3: A capture taken while `arb_valid` is low loads 0x00, so its type field is zero, meaning no source needs service.
- R4: Without an acknowledge or update strobe, `cir_q` holds its value whatever the arbitration inputs do.
- R5: `vec_valid` is high for exactly the one cycle after each edge with `ack_stb` high, and it stays low after an update-only capture.
- R6: With `cfg_use_base` low at the acknowledge edge, the vector is the fixed value 0x0F, whatever the modification mode.
- R7: `base_wr` loads `base_wdata` into the base register. With `cfg_use_base` high and `cfg_mod_mode` = 00, the vector equals the base register as it stood before the acknowledge edge.
- R8: With `cfg_use_base` high, the modification mode controls which base bits are replaced. Mode 01 replaces bits 2:0 with the captured type code. Mode 10 replaces bit 3 with the captured channel. Mode 11 does both. All other bits come from the base register.
- R9: When modification is on and nothing is pending at the acknowledge, the inserted type and channel bits are all zero.
- R10: `ctx_chan` equals `cir_q` bit 7. `fifo_rd`/`fifo_wr` are one-hot copies of `glob_rd`/`glob_wr` at bit index `ctx_chan`, in the same cycle. They are all-zero when no global access is requested.
- R11: If acknowledge and update strobes arrive in the same cycle, the result is a single capture of the arbitration value plus one vector-valid pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| arb_valid | input | 1 | Arbitration winner exceeds threshold |
| arb_chan | input | 1 | Winning channel |
| arb_type | input | 3 | Winning type code |
| arb_prio | input | 4 | Winning priority value |
| ack_stb | input | 1 | Interrupt-acknowledge strobe |
| upd_stb | input | 1 | Update-snapshot command strobe |
| cfg_use_base | input | 1 | 1 = base register vector, 0 = fixed vector |
| cfg_mod_mode | input | 2 | 00 none, 01 type, 10 channel, 11 both |
| base_wr | input | 1 | Base register write enable |
| base_wdata | input | 8 | Base register write data |
| glob_rd | input | 1 | Global FIFO alias read |
| glob_wr | input | 1 | Global FIFO alias write |
| cir_q | output | 8 | Current-interrupt snapshot |
| vec_q | output | 8 | Vector of the last acknowledge |
| vec_valid | output | 1 | Vector valid, one cycle after acknowledge |
| ctx_chan | output | 1 | Current interrupt context channel |
| fifo_rd | output | 2 | Per-channel FIFO read select |
| fifo_wr | output | 2 | Per-channel FIFO write select |

## Verification
The hardest cases to reach from the ports are these:

- A modified vector taken while nothing is pending, where a stale channel or type could leak into the inserted bits.
- Simultaneous acknowledge and update strobes.
- A base write in the same cycle as an acknowledge.

The random stimulus draws the valid flag, the strobes, the mode and base writes independently each cycle, so these overlaps occur many times. Directed sequences also force a snapshot with channel B and type 7, followed by an acknowledge with nothing pending in mode 11. Global accesses are issued after captures of both channels, so the steering outputs are seen to follow the snapshot.

// File: rtl/irq_ack_pkg.sv
package irq_ack_pkg;
   typedef enum logic [1:0] {
      MOD_NONE = 2'b00,
      MOD_TYPE = 2'b01,
      MOD_CHAN = 2'b10,
      MOD_BOTH = 2'b11
   } mod_mode_e;
endpackage

// File: rtl/irq_snap_reg.sv
module irq_snap_reg #(
   parameter int CH_W   = 1,
   parameter int TYPE_W = 3,
   parameter int PRI_W  = 4
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        cap_en,
   input  logic                        arb_valid,
   input  logic [CH_W-1:0]             arb_chan,
   input  logic [TYPE_W-1:0]           arb_type,
   input  logic [PRI_W-1:0]            arb_prio,
   output logic [CH_W+TYPE_W+PRI_W-1:0] snap_next,
   output logic [CH_W+TYPE_W+PRI_W-1:0] cir_q
);
   localparam int CIR_W = CH_W + TYPE_W + PRI_W;

   // value that a capture would load right now
   always_comb begin
      if (arb_valid) snap_next = {arb_chan, arb_type, arb_prio};
      else           snap_next = '0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      cir_q <= '0;
      else if (cap_en) cir_q <= snap_next;
   end

   // R2
   cap_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_en && arb_valid) |=> (cir_q == $past({arb_chan, arb_type, arb_prio})));
   // R3
   cap_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cap_en && !arb_valid) |=> (cir_q == {CIR_W{1'b0}}));
   // R4
   cap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !cap_en |=> $stable(cir_q));
endmodule

// File: rtl/irq_vec_build.sv
module irq_vec_build
   import irq_ack_pkg::*;
#(
   parameter int             VEC_W     = 8,
   parameter int             CH_W      = 1,
   parameter int             TYPE_W    = 3,
   parameter bit             MOD_EN    = 1'b1,
   parameter logic [VEC_W-1:0] FIXED_VEC = 8'h0F,
   parameter logic [VEC_W-1:0] BASE_RST  = 8'h0F
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ack,
   input  logic              use_base,
   input  logic [1:0]        mod_mode,
   input  logic              base_wr,
   input  logic [VEC_W-1:0]  base_wdata,
   input  logic [TYPE_W-1:0] snap_type,
   input  logic [CH_W-1:0]   snap_chan,
   output logic [VEC_W-1:0]  vec_q,
   output logic              vec_valid
);
   localparam int CH_LSB = TYPE_W;

   logic [VEC_W-1:0] base_q;
   logic [VEC_W-1:0] mod_vec;
   logic [VEC_W-1:0] next_vec;
   mod_mode_e        mm;

   assign mm = mod_mode_e'(mod_mode);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       base_q <= BASE_RST;
      else if (base_wr) base_q <= base_wdata;
   end

   generate
      if (MOD_EN) begin : g_mod
         always_comb begin
            mod_vec = base_q;
            if (mm == MOD_TYPE || mm == MOD_BOTH)
               mod_vec[TYPE_W-1:0] = snap_type;
            if (mm == MOD_CHAN || mm == MOD_BOTH)
               mod_vec[CH_LSB +: CH_W] = snap_chan;
         end
      end else begin : g_plain
         assign mod_vec = base_q;
      end
   endgenerate

   assign next_vec = use_base ? mod_vec : FIXED_VEC;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vec_q     <= '0;
         vec_valid <= 1'b0;
      end else begin
         vec_valid <= ack;
         if (ack) vec_q <= next_vec;
      end
   end

   // R5
   vec_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ack |=> vec_valid);
   // R5
   vec_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ack |=> !vec_valid);
   // R6
   vec_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && !use_base) |=> (vec_q == FIXED_VEC));
   // R7
   vec_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && use_base && mod_mode == 2'b00) |=> (vec_q == $past(base_q)));
endmodule

// File: rtl/irq_ctx_steer.sv
module irq_ctx_steer #(
   parameter int NUM_CH = 2,
   parameter int CH_W   = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [CH_W-1:0]   ctx_chan,
   input  logic              glob_rd,
   input  logic              glob_wr,
   output logic [NUM_CH-1:0] fifo_rd,
   output logic [NUM_CH-1:0] fifo_wr
);
   generate
      for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
         assign fifo_rd[i] = glob_rd && (ctx_chan == CH_W'(i));
         assign fifo_wr[i] = glob_wr && (ctx_chan == CH_W'(i));
      end
   endgenerate

   // R10
   steer_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(fifo_rd) && $onehot0(fifo_wr));
   // R10
   steer_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_rd != '0) |-> glob_rd);
endmodule

// File: rtl/irq_ack_vector.sv
module irq_ack_vector #(
   parameter int          NUM_CH    = 2,
   parameter int          TYPE_W    = 3,
   parameter int          PRI_W     = 4,
   parameter int          VEC_W     = 8,
   parameter bit          MOD_EN    = 1'b1,
   parameter logic [7:0]  FIXED_VEC = 8'h0F,
   parameter logic [7:0]  BASE_RST  = 8'h0F
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        arb_valid,
   input  logic [0:0]  arb_chan,
   input  logic [2:0]  arb_type,
   input  logic [3:0]  arb_prio,
   input  logic        ack_stb,
   input  logic        upd_stb,
   input  logic        cfg_use_base,
   input  logic [1:0]  cfg_mod_mode,
   input  logic        base_wr,
   input  logic [7:0]  base_wdata,
   input  logic        glob_rd,
   input  logic        glob_wr,
   output logic [7:0]  cir_q,
   output logic [7:0]  vec_q,
   output logic        vec_valid,
   output logic [0:0]  ctx_chan,
   output logic [1:0]  fifo_rd,
   output logic [1:0]  fifo_wr
);
   localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1;
   localparam int CIR_W = CH_W + TYPE_W + PRI_W;
   localparam int CH_POS = CIR_W - 1;
   localparam int TY_LSB = PRI_W;

   generate
      if (NUM_CH != 2 || CH_W != 1)
         begin : g_bad_ch  $error("port list sized for two channels"); end
      if (CIR_W != 8 || VEC_W != 8)
         begin : g_bad_w   $error("snapshot and vector must be 8 bits"); end
      if (TYPE_W + CH_W > VEC_W)
         begin : g_bad_mod $error("inserted fields exceed vector width"); end
   endgenerate

   logic             cap_en;
   logic [CIR_W-1:0] snap_next;

   assign cap_en = ack_stb | upd_stb;

   irq_snap_reg #(.CH_W(CH_W), .TYPE_W(TYPE_W), .PRI_W(PRI_W)) u_snap (
      .clk       (clk),
      .rst_n     (rst_n),
      .cap_en    (cap_en),
      .arb_valid (arb_valid),
      .arb_chan  (arb_chan),
      .arb_type  (arb_type),
      .arb_prio  (arb_prio),
      .snap_next (snap_next),
      .cir_q     (cir_q)
   );

   irq_vec_build #(
      .VEC_W(VEC_W), .CH_W(CH_W), .TYPE_W(TYPE_W), .MOD_EN(MOD_EN),
      .FIXED_VEC(FIXED_VEC), .BASE_RST(BASE_RST)
   ) u_vec (
      .clk        (clk),
      .rst_n      (rst_n),
      .ack        (ack_stb),
      .use_base   (cfg_use_base),
      .mod_mode   (cfg_mod_mode),
      .base_wr    (base_wr),
      .base_wdata (base_wdata),
      .snap_type  (snap_next[TY_LSB +: TYPE_W]),
      .snap_chan  (snap_next[CH_POS -: CH_W]),
      .vec_q      (vec_q),
      .vec_valid  (vec_valid)
   );

   assign ctx_chan = cir_q[CH_POS -: CH_W];

   irq_ctx_steer #(.NUM_CH(NUM_CH), .CH_W(CH_W)) u_steer (
      .clk      (clk),
      .rst_n    (rst_n),
      .ctx_chan (ctx_chan),
      .glob_rd  (glob_rd),
      .glob_wr  (glob_wr),
      .fifo_rd  (fifo_rd),
      .fifo_wr  (fifo_wr)
   );

   // R11
   dual_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_stb && upd_stb && arb_valid) |=>
         (vec_valid && cir_q == $past({arb_chan, arb_type, arb_prio})));
   // R9
   empty_mod_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_stb && !arb_valid && cfg_use_base && cfg_mod_mode == 2'b11) |=>
         (vec_q[3:0] == 4'h0));
endmodule

// File: tb/irq_ack_vector_tb.sv
module irq_ack_vector_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       arb_valid = 0, ack_stb = 0, upd_stb = 0;
   logic [0:0] arb_chan = 0;
   logic [2:0] arb_type = 0;
   logic [3:0] arb_prio = 0;
   logic       cfg_use_base = 0, base_wr = 0, glob_rd = 0, glob_wr = 0;
   logic [1:0] cfg_mod_mode = 0;
   logic [7:0] base_wdata = 0;
   logic [7:0] cir_q, vec_q;
   logic       vec_valid;
   logic [0:0] ctx_chan;
   logic [1:0] fifo_rd, fifo_wr;

   int checks = 0;
   int failures = 0;
   logic [7:0] m_cir = 8'h00;
   logic [7:0] m_vec = 8'h00;
   logic [7:0] m_base = 8'h0F;

   always #2.5 clk = ~clk;

   irq_ack_vector u_dut (
      .clk(clk), .rst_n(rst_n), .arb_valid(arb_valid), .arb_chan(arb_chan),
      .arb_type(arb_type), .arb_prio(arb_prio), .ack_stb(ack_stb),
      .upd_stb(upd_stb), .cfg_use_base(cfg_use_base),
      .cfg_mod_mode(cfg_mod_mode), .base_wr(base_wr), .base_wdata(base_wdata),
      .glob_rd(glob_rd), .glob_wr(glob_wr), .cir_q(cir_q), .vec_q(vec_q),
      .vec_valid(vec_valid), .ctx_chan(ctx_chan), .fifo_rd(fifo_rd),
      .fifo_wr(fifo_wr)
   );

   function automatic logic [7:0] snap_f(logic v, logic ch, logic [2:0] ty,
                                         logic [3:0] pr);
      return v ? {ch, ty, pr} : 8'h00;
   endfunction

   function automatic logic [7:0] vec_f(logic ub, logic [1:0] md,
                                        logic [7:0] base, logic [7:0] snap);
      logic [7:0] r;
      if (!ub) return 8'h0F;
      r = base;
      if (md[0]) r[2:0] = snap[6:4];
      if (md[1]) r[3] = snap[7];
      return r;
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // inputs set at a negedge; runs one clock and checks
   task automatic run_cycle();
      logic [7:0] snap;
      logic       exp_valid;
      string      cir_req, vec_req;
      #1;
      chk("R10 ctx_chan", ctx_chan, m_cir[7]);
      chk("R10 fifo_rd", fifo_rd, glob_rd ? (2'b01 << m_cir[7]) : 2'b00);
      chk("R10 fifo_wr", fifo_wr, glob_wr ? (2'b01 << m_cir[7]) : 2'b00);
      snap = snap_f(arb_valid, arb_chan, arb_type, arb_prio);
      exp_valid = ack_stb;
      vec_req = !cfg_use_base ? "R6 vec" : (cfg_mod_mode == 2'b00) ? "R7 vec" :
                (arb_valid ? "R8 vec" : "R9 vec");
      if (ack_stb && upd_stb) cir_req = "R11 cir";
      else if (ack_stb || upd_stb) cir_req = arb_valid ? "R2 cir" : "R3 cir";
      else cir_req = "R4 cir";
      if (ack_stb) m_vec = vec_f(cfg_use_base, cfg_mod_mode, m_base, snap);
      if (ack_stb || upd_stb) m_cir = snap;
      if (base_wr) m_base = base_wdata;
      @(posedge clk);
      @(negedge clk);
      chk(cir_req, cir_q, m_cir);
      chk(ack_stb && upd_stb ? "R11 valid" : "R5 valid", vec_valid, exp_valid);
      if (exp_valid) chk(vec_req, vec_q, m_vec);
      ack_stb = 0; upd_stb = 0; base_wr = 0; glob_rd = 0; glob_wr = 0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      failures++;
      $display("FAIL watchdog actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      void'($urandom(32'd20517));
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 cir", cir_q, 8'h00);
      chk("R1 vec", vec_q, 8'h00);
      chk("R1 valid", vec_valid, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 base reset value via ack, mode none
      arb_valid = 1; arb_chan = 1; arb_type = 3'd5; arb_prio = 4'd9;
      cfg_use_base = 1; cfg_mod_mode = 2'b00; ack_stb = 1;
      run_cycle();
      chk("R1 base", vec_q, 8'h0F);
      // R10 steering on channel B context
      glob_rd = 1; glob_wr = 1; run_cycle();
      // R9 snapshot B/type 7, then empty ack in mode 11
      arb_valid = 1; arb_chan = 1; arb_type = 3'd7; arb_prio = 4'hF;
      upd_stb = 1; run_cycle();
      base_wr = 1; base_wdata = 8'hFF; run_cycle();
      arb_valid = 0; cfg_mod_mode = 2'b11; ack_stb = 1; run_cycle();
      chk("R9 vec", vec_q, 8'hF0);
      // R11 dual strobe
      arb_valid = 1; arb_chan = 0; arb_type = 3'd2; arb_prio = 4'd3;
      ack_stb = 1; upd_stb = 1; run_cycle();
      // R6 fixed with modification requested
      cfg_use_base = 0; cfg_mod_mode = 2'b11; ack_stb = 1; run_cycle();
      // R5 update only gives no pulse
      upd_stb = 1; run_cycle();
      // random mix
      for (int i = 0; i < 1500; i++) begin
         logic [3:0] op;
         arb_valid = ($urandom_range(0, 3) != 0);
         arb_chan = 1'($urandom); arb_type = 3'($urandom);
         arb_prio = 4'($urandom);
         cfg_use_base = ($urandom_range(0, 3) != 0);
         cfg_mod_mode = 2'($urandom);
         op = 4'($urandom);
         ack_stb = op[0]; upd_stb = op[1] & op[2];
         base_wr = ($urandom_range(0, 4) == 0); base_wdata = 8'($urandom);
         glob_rd = op[3]; glob_wr = ($urandom_range(0, 1) == 1);
         run_cycle();
      end
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule